// File: doc/BRIEF.md
# Caption Line Bit Serializer

This block sends two caption bytes per field as a single-bit stream on the video line that carries captions. When the line-reference strobe arrives on a line flagged as the caption line, the block latches the selected field's two bytes, its enable and the start delay. After the delay it shifts out a run-in burst, a three-bit start code and then both bytes. Each byte is sent least significant bit first, and the block replaces bit 7 with a computed odd-parity bit. The output is a logic data level together with a window signal. A downstream mixer uses these to switch the caption waveform into the analog video path.

Each field has its own byte registers and its own enable. The field-identity input picks the set to use. When the selected field is disabled, the line stays at blanking level, and a line-reference strobe that arrives while a transmission is running has no effect.

The control path is a five-state machine:
- IDLE waits for a qualified strobe.
- WAIT counts the start delay down.
- RUNIN sends the clock run-in.
- FRAME sends the start code.
- DATA sends the two bytes.

It moves through these transitions:
- IDLE→WAIT on a strobe, taken only when the caption line is flagged and the field is enabled.
- WAIT→RUNIN when the delay count reaches zero.
- RUNIN→FRAME at the end of the last run-in bit slot.
- FRAME→DATA at the end of the last start-code bit.
- DATA→IDLE at the end of bit 7 of the second byte.

Top module: `cc_line_serializer`

## Requirements
- R1: During and right after reset, `cc_bit` and `cc_valid` are 0 and the machine is idle.
- R2: The transmission starts on a clock edge where `line_ref` and `cap_line` are both high and the selected field is enabled. `cc_valid` first goes high start_dly+1 clock cycles after that edge, where start_dly is the value sampled at the edge.
- R3: Each transmitted bit holds for exactly BIT_CLKS clocks, and `cc_valid` stays high for 33×BIT_CLKS consecutive clocks.
- R4: The first 14 bit slots form the run-in: 1,0,1,0,… and the first slot is 1.
- R5: Bit slots 14, 15 and 16 carry the start code 0,0,1 in that order.
- R6: Slots 17–24 carry byte 0 and slots 25–32 carry byte 1, each least significant bit first.
- R7: The bit in the bit-7 position of each byte (slots 24 and 32) is not the register's bit 7. It is set so that the eight bits sent for that byte hold an odd number of ones.
- R8: When `field_odd`=1 the block uses `odd_b0`, `odd_b1` and `en_odd`; when `field_odd`=0 it uses `even_b0`, `even_b1` and `en_even`.
- R9: If the selected field's enable is 0 when the strobe arrives, `cc_valid` and `cc_bit` stay 0 for the whole line.
- R10: A `line_ref` strobe has no effect while `cap_line` is 0, and none while a transmission (delay or bits) is in progress.
- R11: The bytes, the field and the delay are sampled at the starting strobe. Register changes after that edge do not alter the transmission in progress.
- R12: Outside the transmission window, `cc_bit` is 0 (blanking level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_ref | input | 1 | One-clock horizontal reference strobe of the current line |
| cap_line | input | 1 | High while the current line is the caption line |
| field_odd | input | 1 | Field identity: 1 = odd field, 0 = even field |
| en_odd | input | 1 | Caption enable for odd fields |
| en_even | input | 1 | Caption enable for even fields |
| odd_b0 | input | 8 | First caption byte, odd field |
| odd_b1 | input | 8 | Second caption byte, odd field |
| even_b0 | input | 8 | First caption byte, even field |
| even_b1 | input | 8 | Second caption byte, even field |
| start_dly | input | DLY_W | Clocks from the strobe to the first bit, minus one |
| cc_bit | output | 1 | Serial data level (0 = blanking) |
| cc_valid | output | 1 | High during the 33-bit transmission window |

## Verification
The bench compares every clock of each caption line against a stream built from the requirements. This check covers the delay, every bit boundary, the run-in, the start code, both bytes and the trailing blank. It uses byte values whose low seven bits hold an even count of ones and values whose count is odd, so both parity outcomes appear. It also uses a byte with bit 7 set and clear low bits, which shows whether parity overwrites the register bit or copies it. Odd and even fields use different bytes and enables, which exposes a swapped field select. Further lines test a disabled field, a strobe off the caption line, a strobe during transmission, and registers rewritten mid-line, which separates latching at the strobe from live reading. Delays of 0, 10 and 37 distinguish an off-by-one in the delay counter from a bit-length error.

// File: rtl/cc_ser_pkg.sv
package cc_ser_pkg;

    localparam int RUNIN_BITS = 14;
    localparam int SYNC_BITS  = 3;
    localparam int BYTE_BITS  = 8;
    localparam int FRAME_LEN  = RUNIN_BITS + SYNC_BITS + 2 * BYTE_BITS;
    localparam int IDX_W      = $clog2(FRAME_LEN);
    localparam int B0_LO      = RUNIN_BITS + SYNC_BITS;
    localparam int B1_LO      = B0_LO + BYTE_BITS;

    // start code in send order: slot0=0, slot1=0, slot2=1
    localparam logic [SYNC_BITS-1:0] SYNC_CODE = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RUNIN,
        ST_FRAME,
        ST_DATA
    } ser_state_t;

    // odd parity over the low seven bits placed in bit 7
    function automatic logic [BYTE_BITS-1:0] with_parity(input logic [BYTE_BITS-1:0] b);
        return {~(^b[BYTE_BITS-2:0]), b[BYTE_BITS-2:0]};
    endfunction

endpackage

// File: rtl/cc_frame_build.sv
module cc_frame_build
    import cc_ser_pkg::*;
(
    input  logic [BYTE_BITS-1:0] byte0,
    input  logic [BYTE_BITS-1:0] byte1,
    output logic [FRAME_LEN-1:0] frame
);

    // run-in: alternating slots, first slot high
    genvar g;
    generate
        for (g = 0; g < RUNIN_BITS; g++) begin : g_runin
            localparam logic SLOT_VAL = ((g % 2) == 0) ? 1'b1 : 1'b0;
            assign frame[g] = SLOT_VAL;
        end
    endgenerate

    assign frame[RUNIN_BITS +: SYNC_BITS] = SYNC_CODE;
    assign frame[B0_LO +: BYTE_BITS]      = with_parity(byte0);
    assign frame[B1_LO +: BYTE_BITS]      = with_parity(byte1);

endmodule

// File: rtl/cc_bit_timer.sv
module cc_bit_timer #(
    parameter int BIT_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    generate
        if (BIT_CLKS == 1) begin : g_single
            assign tick = run;
        end else begin : g_count
            localparam int CNT_W = $clog2(BIT_CLKS);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_CLKS - 1);
            logic [CNT_W-1:0] cnt;

            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == LAST);

            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R3
        end
    endgenerate

endmodule

// File: rtl/cc_ser_fsm.sv
module cc_ser_fsm
    import cc_ser_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_ref,
    input  logic                 cap_line,
    input  logic                 en_sel,
    input  logic [FRAME_LEN-1:0] frame_in,
    input  logic [DLY_W-1:0]     dly_in,
    input  logic                 tick,
    output logic                 run,
    output logic                 cc_bit,
    output logic                 cc_valid
);

    localparam logic [IDX_W-1:0] RUNIN_END = IDX_W'(RUNIN_BITS - 1);
    localparam logic [IDX_W-1:0] SYNC_END  = IDX_W'(RUNIN_BITS + SYNC_BITS - 1);
    localparam logic [IDX_W-1:0] DATA_END  = IDX_W'(FRAME_LEN - 1);

    ser_state_t           state, state_nx;
    logic [IDX_W-1:0]     idx;
    logic [DLY_W-1:0]     dly_cnt;
    logic [FRAME_LEN-1:0] frame_q;
    logic                 start;
    logic                 active;

    assign start  = line_ref && cap_line && en_sel && (state == ST_IDLE);
    assign active = (state == ST_RUNIN) || (state == ST_FRAME) || (state == ST_DATA);
    assign run    = active;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)                      state_nx = ST_WAIT;
            ST_WAIT:  if (dly_cnt == '0)              state_nx = ST_RUNIN;
            ST_RUNIN: if (tick && idx == RUNIN_END)   state_nx = ST_FRAME;
            ST_FRAME: if (tick && idx == SYNC_END)    state_nx = ST_DATA;
            ST_DATA:  if (tick && idx == DATA_END)    state_nx = ST_IDLE;
            default:                                  state_nx = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            dly_cnt <= '0;
            frame_q <= '0;
        end else begin
            state <= state_nx;
            if (start) begin
                frame_q <= frame_in;
                dly_cnt <= dly_in;
                idx     <= '0;
            end else begin
                if (state == ST_WAIT && dly_cnt != '0) begin
                    dly_cnt <= dly_cnt - 1'b1;
                end
                if (active && tick) begin
                    idx <= (state_nx == ST_IDLE) ? '0 : idx + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        cc_valid = active;
        cc_bit   = active ? frame_q[idx] : 1'b0;
    end

    AST_RUNIN_FIRST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_valid) |-> cc_bit); // R4

    AST_RUNIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUNIN && tick && idx != RUNIN_END) |=> (cc_bit != $past(cc_bit))); // R4

    AST_SYNC_LAST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FRAME && idx == SYNC_END) |-> cc_bit); // R5

    AST_PARITY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        cc_valid |-> ((^frame_q[B0_LO +: BYTE_BITS]) && (^frame_q[B1_LO +: BYTE_BITS]))); // R7

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && line_ref && cap_line && !en_sel) |=> (state == ST_IDLE)); // R9

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (active && line_ref) |=> (state != ST_WAIT)); // R10

    AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state == ST_IDLE || $stable(frame_q))); // R11

    AST_BLANK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_WAIT) |-> !cc_bit); // R12

endmodule

// File: rtl/cc_line_serializer.sv
module cc_line_serializer
    import cc_ser_pkg::*;
#(
    parameter int BIT_CLKS = 4,
    parameter int DLY_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_ref,
    input  logic             cap_line,
    input  logic             field_odd,
    input  logic             en_odd,
    input  logic             en_even,
    input  logic [7:0]       odd_b0,
    input  logic [7:0]       odd_b1,
    input  logic [7:0]       even_b0,
    input  logic [7:0]       even_b1,
    input  logic [DLY_W-1:0] start_dly,
    output logic             cc_bit,
    output logic             cc_valid
);

    logic [BYTE_BITS-1:0] sel_b0, sel_b1;
    logic                 sel_en;
    logic [FRAME_LEN-1:0] frame_w;
    logic                 run_w, tick_w;

    // field selection
    always_comb begin
        sel_b0 = field_odd ? odd_b0  : even_b0;
        sel_b1 = field_odd ? odd_b1  : even_b1;
        sel_en = field_odd ? en_odd  : en_even;
    end

    cc_frame_build u_build (
        .byte0 (sel_b0),
        .byte1 (sel_b1),
        .frame (frame_w)
    );

    cc_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_w),
        .tick  (tick_w)
    );

    cc_ser_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_ref (line_ref),
        .cap_line (cap_line),
        .en_sel   (sel_en),
        .frame_in (frame_w),
        .dly_in   (start_dly),
        .tick     (tick_w),
        .run      (run_w),
        .cc_bit   (cc_bit),
        .cc_valid (cc_valid)
    );

endmodule

// File: tb/sim_cc_line_serializer.sv
module sim_cc_line_serializer;

    localparam int B     = 4;
    localparam int DLY_W = 8;
    localparam int NSLOT = 33;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_ref = 1'b0, cap_line = 1'b0, field_odd = 1'b0;
    logic en_odd = 1'b0, en_even = 1'b0;
    logic [7:0] odd_b0 = '0, odd_b1 = '0, even_b0 = '0, even_b1 = '0;
    logic [DLY_W-1:0] start_dly = '0;
    logic cc_bit, cc_valid;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cc_line_serializer #(.BIT_CLKS(B), .DLY_W(DLY_W)) u0 (
        .clk(clk), .rst_n(rst_n), .line_ref(line_ref), .cap_line(cap_line),
        .field_odd(field_odd), .en_odd(en_odd), .en_even(en_even),
        .odd_b0(odd_b0), .odd_b1(odd_b1), .even_b0(even_b0), .even_b1(even_b1),
        .start_dly(start_dly), .cc_bit(cc_bit), .cc_valid(cc_valid)
    );

    function automatic logic [7:0] par(input logic [7:0] b);
        return {~(^b[6:0]), b[6:0]};
    endfunction

    function automatic logic slot_bit(input int k, input logic [7:0] b0, input logic [7:0] b1);
        logic [7:0] p0, p1;
        p0 = par(b0);
        p1 = par(b1);
        if (k < 14)       return (k % 2 == 0);
        else if (k < 16)  return 1'b0;
        else if (k == 16) return 1'b1;
        else if (k < 25)  return p0[k-17];
        else              return p1[k-25];
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // one caption line; glitch_at >= 0 pulses line_ref and rewrites registers there
    task automatic run_line(input logic odd, input logic cap, input int dly, input logic on,
                            input logic [7:0] b0, input logic [7:0] b1,
                            input int glitch_at, input string name);
        int total;
        total = dly + 1 + NSLOT * B + 6;
        @(negedge clk);
        field_odd = odd;
        cap_line  = cap;
        start_dly = DLY_W'(dly);
        line_ref  = 1'b1;
        for (int i = 0; i < total; i++) begin
            logic ev, eb;
            string tag;
            @(negedge clk);
            if (on && i >= dly + 1 && i <= dly + NSLOT * B) begin
                int k;
                k = (i - dly - 1) / B;
                ev = 1'b1;
                eb = slot_bit(k, b0, b1);
                if (k < 14)                tag = "R4";
                else if (k < 17)           tag = "R5";
                else if (k == 24 || k == 32) tag = "R7";
                else                       tag = "R6";
                check("R3", {name, " window"}, cc_valid, ev);
            end else begin
                ev = 1'b0;
                eb = 1'b0;
                if (!cap)          tag = "R10";
                else if (!on)      tag = "R9";
                else if (i <= dly) tag = "R2";
                else               tag = "R12";
                check(tag, {name, " valid"}, cc_valid, ev);
            end
            check(tag, {name, " bit"}, cc_bit, eb);
            line_ref = (i == glitch_at);
            if (i == glitch_at) begin
                odd_b0 = ~odd_b0;   odd_b1 = ~odd_b1;
                even_b0 = ~even_b0; even_b1 = ~even_b1;
                start_dly = 8'd2;
            end
        end
        line_ref = 1'b0;
        cap_line = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "reset bit", cc_bit, 1'b0);
        check("R1", "reset valid", cc_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "post-reset bit", cc_bit, 1'b0);
        check("R1", "post-reset valid", cc_valid, 1'b0);
    endtask

    task automatic t_odd_basic();
        en_odd = 1'b1; en_even = 1'b1;
        odd_b0 = 8'h41; odd_b1 = 8'h13; even_b0 = 8'hAA; even_b1 = 8'h55;
        run_line(1'b1, 1'b1, 10, 1'b1, 8'h41, 8'h13, -1, "R2 odd field");
    endtask

    task automatic t_even_zero_delay();
        en_odd = 1'b1; en_even = 1'b1;
        odd_b0 = 8'h11; odd_b1 = 8'h22; even_b0 = 8'h7F; even_b1 = 8'h80;
        run_line(1'b0, 1'b1, 0, 1'b1, 8'h7F, 8'h80, -1, "R8 even field");
    endtask

    task automatic t_long_delay();
        en_odd = 1'b1;
        odd_b0 = 8'h5A; odd_b1 = 8'hE3;
        run_line(1'b1, 1'b1, 37, 1'b1, 8'h5A, 8'hE3, -1, "R2 long delay");
    endtask

    task automatic t_disabled();
        en_odd = 1'b0; en_even = 1'b1;
        odd_b0 = 8'hFF; odd_b1 = 8'hFF;
        run_line(1'b1, 1'b1, 5, 1'b0, 8'hFF, 8'hFF, -1, "R9 odd disabled");
        en_odd = 1'b1; en_even = 1'b0;
        even_b0 = 8'h3C; even_b1 = 8'hC3;
        run_line(1'b0, 1'b1, 5, 1'b0, 8'h3C, 8'hC3, -1, "R8 even disabled");
    endtask

    task automatic t_not_caption_line();
        en_odd = 1'b1; en_even = 1'b1;
        run_line(1'b1, 1'b0, 4, 1'b0, 8'h00, 8'h00, -1, "R10 not caption line");
    endtask

    task automatic t_retrigger();
        en_odd = 1'b1; en_even = 1'b1;
        odd_b0 = 8'h2C; odd_b1 = 8'h91;
        run_line(1'b1, 1'b1, 6, 1'b1, 8'h2C, 8'h91, 6 + 40, "R11 regs rewritten");
        odd_b0 = 8'h0F; odd_b1 = 8'hF0;
        run_line(1'b1, 1'b1, 3, 1'b1, 8'h0F, 8'hF0, 2, "R10 strobe in delay");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_odd_basic();
        t_even_zero_delay();
        t_long_delay();
        t_disabled();
        t_not_caption_line();
        t_retrigger();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule